// File: doc/BRIEF.md
# Decrementing Loop Predicate Generator

This unit turns two unsigned scalars, a start value and a limit, into a vector predicate for a down-counting loop. It visits the vector's elements from the top index down to index 0. At each element it compares the current start value with the limit, then lowers the start value by one. An element is active only while every compare made so far, at that element and at all higher elements, has succeeded. The first failing compare therefore clears that element and every element below it.

The predicate holds one bit per byte of the vector. The element size sets how many elements there are and how their bits are spread across the byte lanes. A width select chooses whether the scalars are compared as 32-bit or 64-bit quantities. A mode select chooses strictly-greater or greater-or-equal. Four condition flags are derived from the result. Inputs are sampled on a clock edge when `in_valid` is high, and the result shows up one cycle later with `out_valid`.

Top module: `dec_loop_pred`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high in the following cycle. Otherwise `out_valid` is low, and the predicate and flags keep their previous values.
- R2: With `strict_sel`=1 an element's compare is unsigned current > limit. With `strict_sel`=0 it is unsigned current >= limit.
- R3: The compare results are ANDed cumulatively from the top element downward. Once a compare fails, that element and every lower-numbered element are inactive, even if a later compare succeeds.
- R4: The current value used by the top element is the start value itself. Each lower element sees a value one less, whatever the element size.
- R5: An element's result bit sits in the lowest byte lane of that element (lane index = element index × bytes per element). All other lanes read 0.
- R6: With `wide_sel`=0 only bits [31:0] of both scalars take part, and the decrement wraps modulo 2^32. With `wide_sel`=1 all 64 bits take part, and the decrement wraps modulo 2^64.
- R7: In greater-or-equal mode with a limit of zero (within the selected width), every element is active.
- R8: `flag_n` = element 0 active; `flag_z` = no element active; `flag_c` = top element inactive; `flag_v` = 0.
- R9: `esize` codes 0, 1, 2, 3 select 8-, 16-, 32- and 64-bit elements. The element count is VL_BITS divided by the element width.
- R10: While reset is asserted, `out_valid`, the predicate and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample the operands at this edge |
| start_val | input | XLEN | Start scalar, decremented per element |
| limit_val | input | XLEN | Limit scalar |
| wide_sel | input | 1 | 1: full-width compare, 0: low half only |
| esize | input | 2 | Element size code |
| strict_sel | input | 1 | 1: greater-than, 0: greater-or-equal |
| out_valid | output | 1 | Result registered this cycle |
| pred | output | VL_BITS/8 | Predicate, one bit per byte lane |
| flag_n | output | 1 | Lowest element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Highest element inactive |
| flag_v | output | 1 | Always zero |

## Verification
Some properties are checked on every cycle whenever a result is valid: the valid pipeline and the holding of outputs, the zero lanes inside each element, the shape of the predicate (a contiguous run of active elements starting at the top), the agreement of the four flags with the predicate, and the all-true result for a zero limit in greater-or-equal mode. Which element is the boundary cannot be checked that way. It depends on the decrement-by-one rule, the choice of compare mode, and the 32-bit truncation and wrap. Only the bench scenarios show those, by checking exact predicates from a loop model at equal, adjacent, zero, maximum and wrapping limits.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/dlp_cmp_chain.sv
// One comparator per possible element (byte granularity). Slot k holds the
// compare for the element k positions below the top element.
module dlp_cmp_chain #(
  parameter int PL   = 32,
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] start_i,
  input  logic [XLEN-1:0] limit_i,
  input  logic            wide_i,
  input  logic            strict_i,
  output logic [PL-1:0]   run_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] lim;
  logic [PL-1:0]   cond;

  assign wmask = wide_i ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign opa   = start_i & wmask;
  assign lim   = limit_i & wmask;

  for (genvar k = 0; k < PL; k++) begin : g_slot
    logic [XLEN-1:0] cur;
    assign cur     = (opa - XLEN'(k)) & wmask;
    assign cond[k] = strict_i ? (cur > lim) : (cur >= lim);
  end

  // Sticky AND from the top element downward.
  always_comb begin
    run_o[0] = cond[0];
    for (int k = 1; k < PL; k++) begin
      run_o[k] = run_o[k-1] & cond[k];
    end
  end
endmodule

// File: rtl/dlp_lane_map.sv
// Places the sticky results into byte lanes for the chosen element size.
module dlp_lane_map #(
  parameter int PL = 32
) (
  input  logic [PL-1:0] run_i,
  input  logic [1:0]    esz_i,
  output logic [PL-1:0] pred_o
);
  for (genvar j = 0; j < PL; j++) begin : g_lane
    logic [3:0] cand;
    for (genvar s = 0; s < 4; s++) begin : g_size
      localparam int SZ = 1 << s;
      localparam int NE = PL / SZ;
      if ((j % SZ) == 0) begin : g_base
        assign cand[s] = run_i[NE - 1 - (j / SZ)];
      end else begin : g_pad
        assign cand[s] = 1'b0;
      end
    end
    assign pred_o[j] = cand[esz_i];
  end
endmodule

// File: rtl/dlp_flags.sv
module dlp_flags
  import dlp_pkg::*;
#(
  parameter int PL = 32
) (
  input  logic [PL-1:0] pred_i,
  input  logic [1:0]    esz_i,
  output nzcv_t         flags_o
);
  localparam int IW = $clog2(PL);

  logic [IW-1:0] top_lane;

  always_comb begin
    top_lane  = IW'(PL - (32'd1 << esz_i));
    flags_o.n = pred_i[0];
    flags_o.z = ~|pred_i;
    flags_o.c = ~pred_i[top_lane];
    flags_o.v = 1'b0;
  end
endmodule

// File: rtl/dec_loop_pred.sv
module dec_loop_pred
  import dlp_pkg::*;
#(
  parameter int VL_BITS = 256,
  parameter int XLEN    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [XLEN-1:0]      start_val,
  input  logic [XLEN-1:0]      limit_val,
  input  logic                 wide_sel,
  input  logic [1:0]           esize,
  input  logic                 strict_sel,
  output logic                 out_valid,
  output logic [VL_BITS/8-1:0] pred,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v
);
  localparam int PL = VL_BITS / 8;

  logic [PL-1:0] run_w;
  logic [PL-1:0] pred_w;
  nzcv_t         flags_w;

  logic [PL-1:0] pred_q,  pred_d;
  nzcv_t         flags_q, flags_d;
  logic          vld_q,   vld_d;

  dlp_cmp_chain #(.PL(PL), .XLEN(XLEN)) i_chain (
    .start_i  (start_val),
    .limit_i  (limit_val),
    .wide_i   (wide_sel),
    .strict_i (strict_sel),
    .run_o    (run_w)
  );

  dlp_lane_map #(.PL(PL)) i_lanes (
    .run_i  (run_w),
    .esz_i  (esize),
    .pred_o (pred_w)
  );

  dlp_flags #(.PL(PL)) i_flags (
    .pred_i  (pred_w),
    .esz_i   (esize),
    .flags_o (flags_w)
  );

  always_comb begin
    vld_d   = in_valid;
    pred_d  = pred_q;
    flags_d = flags_q;
    if (in_valid) begin
      pred_d  = pred_w;
      flags_d = flags_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      pred_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q   <= vld_d;
      pred_q  <= pred_d;
      flags_q <= flags_d;
    end
  end

  assign out_valid = vld_q;
  assign pred      = pred_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_c    = flags_q.c;
  assign flag_v    = flags_q.v;
endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
  parameter int VL_BITS = 256,
  parameter int XLEN    = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [XLEN-1:0]      limit_val,
  input logic                 wide_sel,
  input logic [1:0]           esize,
  input logic                 strict_sel,
  input logic                 out_valid,
  input logic [VL_BITS/8-1:0] pred,
  input logic                 flag_n,
  input logic                 flag_z,
  input logic                 flag_c,
  input logic                 flag_v
);
  localparam int PL   = VL_BITS / 8;
  localparam int HALF = XLEN / 2;

  logic [1:0]    esz_seen;
  logic [PL-1:0] base_mask;
  logic [PL-1:0] low_bit;
  logic [PL-1:0] top_run;
  logic          lim_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        esz_seen <= 2'd0;
    else if (in_valid) esz_seen <= esize;
  end

  always_comb begin
    base_mask = '0;
    for (int j = 0; j < PL; j++) begin
      if ((j % (1 << esz_seen)) == 0) base_mask[j] = 1'b1;
    end
    low_bit  = pred & (~pred + 1'b1);
    top_run  = base_mask & ~(low_bit - 1'b1);
    lim_zero = wide_sel ? (limit_val == '0) : (limit_val[HALF-1:0] == '0);
  end

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pred) && $stable(flag_n) && $stable(flag_z) && $stable(flag_c)));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pred == '0 || pred == top_run));
  p_lane_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((pred & ~base_mask) == '0));
  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !strict_sel && lim_zero) |=> (pred == base_mask));
  p_flag_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_n == pred[0]));
  p_flag_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (pred == '0)));
  p_flag_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_c == !pred[PL - (1 << esz_seen)]));
  p_flag_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flag_v);
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && pred == '0));
endmodule

bind dec_loop_pred dlp_checker #(.VL_BITS(VL_BITS), .XLEN(XLEN)) i_dlp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .limit_val  (limit_val),
  .wide_sel   (wide_sel),
  .esize      (esize),
  .strict_sel (strict_sel),
  .out_valid  (out_valid),
  .pred       (pred),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flag_v     (flag_v)
);

// File: tb/test_dec_loop_pred.sv
`timescale 1ns/1ps
module test_dec_loop_pred;
  import dlp_pkg::*;

  localparam int VL_BITS = 256;
  localparam int XLEN    = 64;
  localparam int PL      = VL_BITS / 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [XLEN-1:0] start_val;
  logic [XLEN-1:0] limit_val;
  logic            wide_sel;
  logic [1:0]      esize;
  logic            strict_sel;
  logic            out_valid;
  logic [PL-1:0]   pred;
  logic            flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  dec_loop_pred #(.VL_BITS(VL_BITS), .XLEN(XLEN)) i_dec_loop_pred (
    .clk, .rst_n, .in_valid, .start_val, .limit_val, .wide_sel, .esize,
    .strict_sel, .out_valid, .pred, .flag_n, .flag_z, .flag_c, .flag_v
  );

  function automatic logic [PL-1:0] model_pred(logic [63:0] s, logic [63:0] l,
                                               logic w, logic [1:0] ez, logic st);
    logic [63:0]   m;
    logic [63:0]   op;
    logic [63:0]   lm;
    logic          last;
    logic          c;
    logic [PL-1:0] r;
    int            n;
    m    = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    op   = s & m;
    lm   = l & m;
    last = 1'b1;
    r    = '0;
    n    = PL >> ez;
    for (int e = n - 1; e >= 0; e--) begin
      c    = st ? (op > lm) : (op >= lm);
      last = last & c;
      r[e << ez] = last;
      op   = (op - 64'd1) & m;
    end
    return r;
  endfunction

  function automatic logic [3:0] model_flags(logic [PL-1:0] p, logic [1:0] ez);
    return {p[0], (p == '0), !p[PL - (1 << ez)], 1'b0};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [63:0] s, logic [63:0] l,
                       logic w, logic [1:0] ez, logic st);
    logic [PL-1:0] ep;
    logic [3:0]    ef;
    @(negedge clk);
    start_val  = s;
    limit_val  = l;
    wide_sel   = w;
    esize      = ez;
    strict_sel = st;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ep = model_pred(s, l, w, ez, st);
    ef = model_flags(ep, ez);
    check("R1 valid", 64'(out_valid), 64'd1);
    check(req, 64'(pred), 64'(ep));
    check("R8 flags", 64'({flag_n, flag_z, flag_c, flag_v}), 64'(ef));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [PL-1:0] held;
    logic [63:0]   s, l;
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; in_valid = 1'b0; start_val = '0; limit_val = '0;
    wide_sel = 1'b1; esize = 2'd0; strict_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset pred", 64'(pred), 64'd0);
    check("R10 reset flags", 64'({flag_n, flag_z, flag_c, flag_v}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: zero limit, greater-or-equal, every size and width
    for (int ez = 0; ez < 4; ez++) begin
      apply("R7 zero limit wide", 64'd3, 64'd0, 1'b1, 2'(ez), 1'b0);
      apply("R7 zero limit narrow", 64'hFFFF_FFFF_0000_0000, 64'hABCD_0000_0000, 1'b0, 2'(ez), 1'b0);
    end
    // R2: limit equal to start, both modes
    apply("R2 equal ge", 64'd100, 64'd100, 1'b1, ESZ_8, 1'b0);
    apply("R2 equal gt", 64'd100, 64'd100, 1'b1, ESZ_8, 1'b1);
    // R4: decrement by one regardless of element size
    apply("R4 dec bytes", 64'd50, 64'd45, 1'b1, ESZ_8, 1'b0);
    apply("R4 dec dwords", 64'd50, 64'd48, 1'b1, ESZ_64, 1'b0);
    apply("R9 halfs", 64'd20, 64'd10, 1'b1, ESZ_16, 1'b1);
    apply("R9 words", 64'd7, 64'd4, 1'b1, ESZ_32, 1'b0);
    // R3: wrap would re-enable a compare, sticky keeps it off
    apply("R3 sticky wrap", 64'd1, 64'd0, 1'b1, ESZ_8, 1'b1);
    apply("R3 sticky wrap narrow", 64'd2, 64'd1, 1'b0, ESZ_16, 1'b1);
    // R6: upper bits ignored in narrow mode, used in wide mode
    apply("R6 narrow upper ignored", 64'hFFFF_0000_0000_0010, 64'h0000_0001_0000_0008, 1'b0, ESZ_8, 1'b0);
    apply("R6 wide upper used", 64'hFFFF_0000_0000_0010, 64'h0000_0001_0000_0008, 1'b1, ESZ_8, 1'b0);
    // max limit
    apply("R2 max limit ge", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, ESZ_8, 1'b0);
    apply("R2 max limit gt", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, ESZ_8, 1'b1);
    apply("R5 lanes", 64'd9, 64'd8, 1'b1, ESZ_32, 1'b0);

    // R1: outputs hold while in_valid is low
    held = pred;
    @(negedge clk);
    start_val = 64'd0; limit_val = 64'd500; esize = 2'd0;
    @(negedge clk);
    check("R1 hold valid", 64'(out_valid), 64'd0);
    check("R1 hold pred", 64'(pred), 64'(held));

    for (int i = 0; i < 1500; i++) begin
      s = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: l = s - 64'($urandom_range(0, PL + 2));
        1: l = {$urandom, $urandom};
        2: l = {32'($urandom), s[31:0] - 32'($urandom_range(0, PL + 2))};
        default: l = 64'($urandom_range(0, 3));
      endcase
      apply("R2 R4 R5 R9 random", s, l, 1'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule